// File: doc/BRIEF.md
# Masked Vector Gather Load Sequencer

This block performs a masked gather of up to eight elements from memory into a vector destination register. A start pulse captures a base address, eight signed 64-bit indices, a 2-bit scale code, a per-lane completion mask, an element-size select and the current destination contents. For every lane whose mask bit is set, the block forms an address, issues one load on a simple request/response memory port and writes the returned data into that lane. It then clears the lane's mask bit.

Lanes are visited in ascending order with one load in flight at a time. If a load reports a fault, the block stops at once and names the faulting lane. The destination and mask are left holding every lane gathered so far. Re-running with the returned mask and destination resumes the gather where it stopped. When the data is 32 bits wide and the indices are 64 bits wide, the upper half of the destination and the upper half of the mask do not map to any lane, and they are forced to zero.

The controller has two states. `ST_IDLE` waits for `start`. When start arrives with no active lane, it stays in `ST_IDLE` and pulses `done`; with at least one active lane, it moves to `ST_LOAD`. `ST_LOAD` holds a request for the lowest remaining active lane. It returns to `ST_IDLE` on a faulting response (pulsing `fault`) or on a clean response to the last active lane (pulsing `done`). On a clean response with lanes still left, it stays in `ST_LOAD` and moves on to the next lane.

Top module: `gather_seq`

## Requirements
- R1: The address of lane i is `base_addr` plus the sign-extended 64-bit index slice `idx_vec[64i+63:64i]`, shifted left by `scale` (code 0..3 selects a multiplier of 1, 2, 4 or 8). The sum wraps modulo 2^64.
- R2: Only lanes whose bit in `mask_in[7:0]` is 1 are loaded, one request at a time, in ascending lane order. The destination field of a lane whose bit is 0 keeps its value from `dest_in`.
- R3: A clean response for lane i writes `resp_data` into that lane and clears mask bit i. With `elem64`=1 the field is `dest_out[64i+63:64i]`. With `elem64`=0 the field is `dest_out[32i+31:32i]`, taken from `resp_data[31:0]`. Mask bits are never set by the block.
- R4: When all active lanes finish without a fault, `done` is high for exactly one cycle, `fault` stays low and `mask_out[7:0]` is zero.
- R5: A faulting response for lane i raises `fault` for one cycle with `fault_lane`=i. All active lanes below i are already written and cleared, while lane i and every lane above it keep their mask bit and destination field. The block then returns to idle.
- R6: With `elem64`=0, `dest_out[511:256]` and `mask_out[15:8]` are zero from the cycle after start, even when the first load faults. With `elem64`=1, `mask_out[15:8]` keeps the value of `mask_in[15:8]`.
- R7: A start with `mask_in[7:0]`=0 raises `done` in the first cycle after the start edge and issues no request.
- R8: Inputs are captured only by a start seen while idle. A start pulse while `busy` is high has no effect on the result.
- R9: `req_valid` stays high with `req_addr` stable until `resp_valid`. `req_wide` equals the captured `elem64`.
- R10: After reset, `busy`, `done`, `fault` and `req_valid` are low, and `dest_out` and `mask_out` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a gather; honoured only while idle |
| elem64 | input | 1 | 1: 64-bit elements, 0: 32-bit elements |
| scale | input | 2 | Index shift amount (multiplier 1, 2, 4, 8) |
| base_addr | input | 64 | Base address |
| idx_vec | input | 512 | Eight signed 64-bit indices, lane 0 in the low bits |
| mask_in | input | 16 | Completion mask; bits 7:0 select lanes |
| dest_in | input | 512 | Current destination contents |
| req_valid | output | 1 | Load request pending |
| req_addr | output | 64 | Load address |
| req_wide | output | 1 | Load size, 1 = 64 bits |
| resp_valid | input | 1 | Load response present |
| resp_fault | input | 1 | Response reports a fault |
| resp_data | input | 64 | Loaded data |
| dest_out | output | 512 | Destination register |
| mask_out | output | 16 | Remaining mask |
| busy | output | 1 | Gather in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | One-cycle fault pulse |
| fault_lane | output | 3 | Lane that faulted |

## Verification
Completion and lane writeback share a clock edge. The response to the last active lane writes its data, clears its mask bit and raises `done` all at once. The bench uses a memory model whose latency can be set to zero, so a request and its response fall in the same cycle. Under that setting, writeback and selection of the next lane happen back to back on every edge. The final destination, the zero mask and a single-cycle `done` are then compared against a lane-by-lane model. The same collision is also provoked for a fault on the first active lane in 32-bit mode: the result is judged by `fault_lane`, the untouched mask bits and the already zeroed upper halves.

// File: rtl/gather_pkg.sv
package gather_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_LOAD = 1'b1
    } gather_state_t;

endpackage

// File: rtl/gather_pick.sv
// Lowest-set-bit finder over the active lane mask.
module gather_pick #(
    parameter int N  = 8,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/gather_addr.sv
// Lane address: base + (sign-extended index << scale), modulo 2^W.
module gather_addr #(
    parameter int LANES = 8,
    parameter int W     = 64,
    localparam int LW   = $clog2(LANES)
) (
    input  logic [W-1:0]       base,
    input  logic [LANES*W-1:0] idx_vec,
    input  logic [LW-1:0]      lane,
    input  logic [1:0]         scale,
    output logic [W-1:0]       addr
);
    logic [W-1:0] lane_idx [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_slice
        assign lane_idx[g] = idx_vec[g*W +: W];
    end

    assign addr = base + (lane_idx[lane] << scale);
endmodule

// File: rtl/gather_seq.sv
module gather_seq #(
    parameter int LANES  = 8,
    parameter int W      = 64,
    localparam int LW    = $clog2(LANES),
    localparam int DEST_W = LANES * W,
    localparam int HALF_W = DEST_W / 2,
    localparam int MASK_W = 2 * LANES,
    localparam int DOFF_W = $clog2(DEST_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              elem64,
    input  logic [1:0]        scale,
    input  logic [W-1:0]      base_addr,
    input  logic [DEST_W-1:0] idx_vec,
    input  logic [MASK_W-1:0] mask_in,
    input  logic [DEST_W-1:0] dest_in,
    output logic              req_valid,
    output logic [W-1:0]      req_addr,
    output logic              req_wide,
    input  logic              resp_valid,
    input  logic              resp_fault,
    input  logic [W-1:0]      resp_data,
    output logic [DEST_W-1:0] dest_out,
    output logic [MASK_W-1:0] mask_out,
    output logic              busy,
    output logic              done,
    output logic              fault,
    output logic [LW-1:0]     fault_lane
);
    import gather_pkg::*;

    gather_state_t     state_q, state_d;
    logic [W-1:0]      base_q;
    logic [DEST_W-1:0] idx_q;
    logic [1:0]        scale_q;
    logic              wide_q;
    logic [DEST_W-1:0] dest_q;
    logic [MASK_W-1:0] mask_q;
    logic              done_q, fault_q;
    logic [LW-1:0]     flane_q;

    // start-time lane presence
    logic          start_any;
    logic [LW-1:0] start_lane;

    gather_pick #(.N(LANES)) i_pick_start (
        .req (mask_in[LANES-1:0]),
        .any (start_any),
        .idx (start_lane)
    );

    // current lane during loading
    logic          cur_any;
    logic [LW-1:0] cur_lane;

    gather_pick #(.N(LANES)) i_pick_cur (
        .req (mask_q[LANES-1:0]),
        .any (cur_any),
        .idx (cur_lane)
    );

    logic [LANES-1:0] cur_onehot;
    logic [LANES-1:0] rest_mask;
    logic             rest_any;
    logic [DOFF_W-1:0] off_wide, off_narrow;

    assign cur_onehot = LANES'(1) << cur_lane;
    assign rest_mask  = mask_q[LANES-1:0] & ~cur_onehot;
    assign rest_any   = |rest_mask;
    assign off_wide   = DOFF_W'(cur_lane) << $clog2(W);
    assign off_narrow = DOFF_W'(cur_lane) << $clog2(W / 2);

    gather_addr #(.LANES(LANES), .W(W)) i_addr (
        .base    (base_q),
        .idx_vec (idx_q),
        .lane    (cur_lane),
        .scale   (scale_q),
        .addr    (req_addr)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start && start_any) state_d = ST_LOAD;
            ST_LOAD: if (resp_valid && (resp_fault || !rest_any)) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath and output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            idx_q   <= '0;
            scale_q <= '0;
            wide_q  <= 1'b0;
            dest_q  <= '0;
            mask_q  <= '0;
            done_q  <= 1'b0;
            fault_q <= 1'b0;
            flane_q <= '0;
        end else begin
            done_q  <= 1'b0;
            fault_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        base_q  <= base_addr;
                        idx_q   <= idx_vec;
                        scale_q <= scale;
                        wide_q  <= elem64;
                        if (elem64) begin
                            dest_q <= dest_in;
                            mask_q <= mask_in;
                        end else begin
                            dest_q <= {{HALF_W{1'b0}}, dest_in[HALF_W-1:0]};
                            mask_q <= {{LANES{1'b0}}, mask_in[LANES-1:0]};
                        end
                        done_q <= !start_any;
                    end
                end
                ST_LOAD: begin
                    if (resp_valid && cur_any) begin
                        if (resp_fault) begin
                            fault_q <= 1'b1;
                            flane_q <= cur_lane;
                        end else begin
                            if (wide_q) dest_q[off_wide +: W] <= resp_data;
                            else        dest_q[off_narrow +: W/2] <= resp_data[W/2-1:0];
                            mask_q <= mask_q & ~MASK_W'(cur_onehot);
                            done_q <= !rest_any;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign req_valid  = (state_q == ST_LOAD);
    assign req_wide   = wide_q;
    assign busy       = (state_q == ST_LOAD);
    assign dest_out   = dest_q;
    assign mask_out   = mask_q;
    assign done       = done_q;
    assign fault      = fault_q;
    assign fault_lane = flane_q;

    logic unused_ok;
    assign unused_ok = ^start_lane;
endmodule

// File: rtl/gather_seq_chk.sv
module gather_seq_chk #(
    parameter int LANES = 8,
    parameter int W     = 64,
    localparam int LW     = $clog2(LANES),
    localparam int DEST_W = LANES * W,
    localparam int MASK_W = 2 * LANES
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              fault,
    input logic [LW-1:0]     fault_lane,
    input logic [MASK_W-1:0] mask_out,
    input logic [DEST_W-1:0] dest_out,
    input logic              req_valid,
    input logic [W-1:0]      req_addr,
    input logic              req_wide,
    input logic              resp_valid
);
    logic [LANES-1:0] mask_lo;
    assign mask_lo = mask_out[LANES-1:0];

    p_done_fault_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fault));

    p_done_mask_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (mask_lo == '0));

    p_fault_lane_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> mask_lo[fault_lane]);

    p_mask_never_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ((mask_out & ~$past(mask_out)) == '0));

    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !resp_valid) |=> (req_valid && $stable(req_addr)));

    p_narrow_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_wide) |->
            ((mask_out[MASK_W-1:LANES] == '0) && (dest_out[DEST_W-1:DEST_W/2] == '0)));
endmodule

bind gather_seq gather_seq_chk #(.LANES(LANES), .W(W)) i_chk (.*);

// File: tb/test_gather_seq.sv
`timescale 1ns/1ps
module test_gather_seq;
    localparam logic [63:0] KEY = 64'hC3C3_0F0F_1234_5678;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         elem64 = 1'b0;
    logic [1:0]   scale = '0;
    logic [63:0]  base_addr = '0;
    logic [511:0] idx_vec = '0;
    logic [15:0]  mask_in = '0;
    logic [511:0] dest_in = '0;
    logic         req_valid, req_wide, resp_valid, resp_fault;
    logic [63:0]  req_addr, resp_data;
    logic [511:0] dest_out;
    logic [15:0]  mask_out;
    logic         busy, done, fault;
    logic [2:0]   fault_lane;

    always #5 clk = ~clk;

    gather_seq i_gather_seq (.*);

    // memory model
    int          lat = 0;
    int          lat_cnt = 0;
    bit          flt_en = 1'b0;
    logic [63:0] flt_addr = '0;
    assign resp_valid = req_valid && (lat_cnt >= lat);
    assign resp_fault = resp_valid && flt_en && (req_addr == flt_addr);
    assign resp_data  = req_addr ^ KEY;
    always @(posedge clk) begin
        if (!req_valid || resp_valid) lat_cnt <= 0;
        else                          lat_cnt <= lat_cnt + 1;
    end

    logic [63:0] seen [64];
    logic        seen_wide [64];
    int          n_seen = 0;
    always @(negedge clk) begin
        if (req_valid && resp_valid) begin
            seen[n_seen % 64]      <= req_addr;
            seen_wide[n_seen % 64] <= req_wide;
            n_seen <= n_seen + 1;
        end
    end

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit timed_out = 1'b0;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 150000 && !timed_out) begin
            timed_out = 1'b1;
            failures++;
            checks++;
            $display("FAIL watchdog: run hung act=%0d exp=<150000 cycles", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [511:0] act, input logic [511:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    logic [511:0] last_dest;
    logic [15:0]  last_mask;

    // one gather with full lane-by-lane expectation
    task automatic run_op(input string tag, input logic [63:0] b, input logic [511:0] iv,
                          input logic [1:0] sc, input bit w, input logic [15:0] m,
                          input logic [511:0] d, input int l, input bit fe,
                          input logic [63:0] fa, input bit poke);
        logic [511:0] exp_d = d;
        logic [15:0]  exp_m = m;
        logic [63:0]  exp_a [8];
        int           n_exp = 0;
        bit           exp_f = 1'b0;
        int           exp_lane = 0;
        int           n0, cyc;
        if (!w) begin
            exp_d[511:256] = '0;
            exp_m[15:8] = '0;
        end
        for (int i = 0; i < 8; i++) begin
            if (!exp_f && exp_m[i]) begin
                logic [63:0] a = b + (iv[i*64 +: 64] << sc);
                exp_a[n_exp] = a;
                n_exp++;
                if (fe && a == fa) begin
                    exp_f = 1'b1;
                    exp_lane = i;
                end else begin
                    if (w) exp_d[i*64 +: 64] = a ^ KEY;
                    else   exp_d[i*32 +: 32] = a[31:0] ^ KEY[31:0];
                    exp_m[i] = 1'b0;
                end
            end
        end
        lat = l; flt_en = fe; flt_addr = fa;
        @(negedge clk);
        n0 = n_seen;
        base_addr = b; idx_vec = iv; scale = sc; elem64 = w; mask_in = m; dest_in = d;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        if (!w) begin
            chk(dest_out[511:256] == '0 && mask_out[15:8] == '0, "R6",
                {tag, " upper zero after start"}, {dest_out[511:256], mask_out[15:8]}, '0);
        end
        while (!(done || fault) && cyc < 200) begin
            if (poke && cyc == 2) begin
                chk(busy, "R8", {tag, " busy before poke"}, 512'(busy), 512'(1));
                base_addr = ~b; mask_in = ~m; dest_in = ~d; elem64 = ~w; scale = ~sc;
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        if (m[7:0] == 8'h00)
            chk(cyc == 1 && done, "R7", {tag, " done one cycle after start"}, 512'(cyc), 512'(1));
        chk(done == !exp_f, "R4", {tag, " done flag"}, 512'(done), 512'(!exp_f));
        chk(fault == exp_f, "R5", {tag, " fault flag"}, 512'(fault), 512'(exp_f));
        if (exp_f)
            chk(fault_lane == 3'(exp_lane), "R5", {tag, " fault lane"},
                512'(fault_lane), 512'(exp_lane));
        chk(dest_out == exp_d, "R3", {tag, " destination"}, dest_out, exp_d);
        chk(mask_out == exp_m, "R3", {tag, " mask"}, 512'(mask_out), 512'(exp_m));
        chk(n_seen - n0 == n_exp, "R2", {tag, " request count"},
            512'(n_seen - n0), 512'(n_exp));
        for (int k = 0; k < n_exp && k < n_seen - n0; k++) begin
            chk(seen[(n0 + k) % 64] == exp_a[k], "R1", {tag, " lane address"},
                512'(seen[(n0 + k) % 64]), 512'(exp_a[k]));
            chk(seen_wide[(n0 + k) % 64] == w, "R9", {tag, " request size"},
                512'(seen_wide[(n0 + k) % 64]), 512'(w));
        end
        @(negedge clk);
        chk(!done && !fault && !busy, "R4", {tag, " pulse lasts one cycle"},
            512'({done, fault, busy}), '0);
        last_dest = dest_out;
        last_mask = mask_out;
    endtask

    function automatic logic [511:0] fill_dest(input logic [31:0] seed);
        logic [511:0] v;
        for (int i = 0; i < 16; i++) v[i*32 +: 32] = seed + 32'(i * 32'h0101_0101);
        return v;
    endfunction

    function automatic logic [511:0] mk_idx(input int mode);
        logic [511:0] v;
        for (int i = 0; i < 8; i++) begin
            if (mode == 0) v[i*64 +: 64] = (i % 2 == 0) ? 64'(i * 3) : -64'(i + 1);
            else           v[i*64 +: 64] = 64'(i * 16) - 64'd40;
        end
        return v;
    endfunction

    task automatic t_reset();
        chk(!busy && !done && !fault && !req_valid, "R10", "reset controls",
            512'({busy, done, fault, req_valid}), '0);
        chk(dest_out == '0 && mask_out == '0, "R10", "reset state",
            {dest_out[255:0], 240'(0), mask_out}, '0);
    endtask

    task automatic t_full_wide();   // R1 R2 R3 R4, zero-latency memory
        run_op("full_wide", 64'h0000_1000_0000_0000, mk_idx(0), 2'd3, 1'b1,
               16'hA5FF, fill_dest(32'h1111_0000), 0, 1'b0, '0, 1'b0);
    endtask

    task automatic t_sparse_narrow();   // R2 R6
        run_op("sparse_narrow", 64'h0000_0000_8000_0000, mk_idx(1), 2'd1, 1'b0,
               16'hFFA6, fill_dest(32'h2222_0000), 2, 1'b0, '0, 1'b0);
    endtask

    task automatic t_fault_resume();    // R5 then resume
        logic [511:0] iv = mk_idx(0);
        logic [63:0]  b = 64'h0000_0000_4000_0000;
        logic [63:0]  fa = b + (iv[5*64 +: 64] << 2);
        run_op("fault_mid", b, iv, 2'd2, 1'b1, 16'h3CFF, fill_dest(32'h3333_0000),
               1, 1'b1, fa, 1'b0);
        run_op("resume", b, iv, 2'd2, 1'b1, last_mask, last_dest, 1, 1'b0, '0, 1'b0);
    endtask

    task automatic t_zero_mask();       // R7 R6
        run_op("zero_mask", 64'h10, mk_idx(1), 2'd0, 1'b0, 16'hFF00,
               fill_dest(32'h4444_0000), 0, 1'b0, '0, 1'b0);
    endtask

    task automatic t_first_fault_narrow();   // R5 R6 same-edge fault, zero latency
        logic [511:0] iv = mk_idx(1);
        logic [63:0]  b = 64'h0000_0000_0002_0000;
        run_op("first_fault", b, iv, 2'd3, 1'b0, 16'h0F18, fill_dest(32'h5555_0000),
               0, 1'b1, b + (iv[3*64 +: 64] << 3), 1'b0);
    endtask

    task automatic t_busy_start();      // R8
        run_op("busy_start", 64'h0000_0000_0100_0000, mk_idx(0), 2'd1, 1'b1,
               16'h0063, fill_dest(32'h6666_0000), 3, 1'b0, '0, 1'b1);
    endtask

    task automatic t_wrap();            // R1 wraparound and most negative index
        logic [511:0] iv = '0;
        iv[0 +: 64]    = 64'd8;
        iv[7*64 +: 64] = 64'h8000_0000_0000_0000;
        run_op("wrap", 64'hFFFF_FFFF_FFFF_FFF0, iv, 2'd2, 1'b1, 16'h0081,
               fill_dest(32'h7777_0000), 1, 1'b0, '0, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_full_wide();
        t_sparse_narrow();
        t_fault_resume();
        t_zero_mask();
        t_first_fault_narrow();
        t_busy_start();
        t_wrap();
        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule